// File: doc/BRIEF.md
# Prioritised Interrupt Controller for a Two-Channel Serial Peripheral

This block arbitrates the interrupts of a dual-channel serial device. Each channel contributes three sources: received data available, transmit buffer empty and an external/status change. Each source has a pending flag and an under-service flag. The six sources have a fixed priority. The block drives an active-low request line. During an acknowledge cycle it marks the winning source as under service. It also joins a daisy chain through an enable input and an enable output.

The host clears pending flags as a side effect of its normal traffic. A write to a channel's data register clears that channel's transmit flag. A read of the data register clears the receive flag. A dedicated command clears the external/status flag and reopens that channel's status latch. A second command retires the highest-priority source under service. While a source is under service, only sources of higher priority can raise a new, nested request. A shared vector register is presented in two forms: one plain, and one with a three-bit source code substituted when status inclusion is switched on.

Top module: `sio_irq_ctrl`

## Requirements
- R1: `int_n` is low exactly when at least one source i satisfies all of the following: `mie`=1, `src_en[i]`=1, `iei`=1, pending bit i is set, no under-service bit at index i or lower is set, and `intack`=0.
- R2: Priority runs by index, with 0 as the highest: 0 channel A receive, 1 A transmit, 2 A ext/status, 3 B receive, 4 B transmit, 5 B ext/status. Channel A is `[0]` of every per-channel port, and `cmd_ch`=0 selects channel A.
- R3: An `ev_rx[c]` or `ev_tx[c]` pulse sets the receive or transmit pending bit of channel c at the next edge. A `data_rd[c]` pulse clears the receive bit and a `data_wr[c]` pulse clears the transmit bit. When a set and a clear of one bit fall in the same cycle, the set wins.
- R4: Each channel's status latch is open after reset and holds the captured value 0. While it is open, an `ext_in[c]` value that differs from the captured value sets the ext/status pending bit, captures the new value and closes the latch. Changes while the latch is closed are ignored. Command code 0x10 written with `cmd_ch`=c clears that pending bit and reopens the latch, so a differing input fires again one cycle later.
- R5: While `intack`=1 and `iei`=1, the first cycle in which `rd_n` is sampled low after being sampled high sets the under-service bit of the highest-priority source that meets R1 without its `intack` term. At most one bit is set per acknowledge.
- R6: While a source is under service, sources of equal or lower priority raise no request, but a pending source of higher priority does.
- R7: Command code 0x38 clears the under-service bit with the lowest index that is set. Under-service bits are not visible on any output.
- R8: `ieo` is high only when `iei`=1 and every pending bit and every under-service bit is clear.
- R9: A `vec_we` pulse loads `vec_wdata` into the vector register. `vec_raw` always shows the register. `vec_mod` equals it when `vis`=0. When `vis`=1, bits [3:1] are replaced by the index of the highest-priority source whose pending and enable bits are both set, or by 3'b111 when there is none.
- R10: `ip_bits[i]` shows pending bit i, in the index order of R2.
- R11: A synchronous active-high `rst` clears all pending bits, all under-service bits and the vector register, and opens both status latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_rx | input | 2 | Per-channel receive-available event pulse |
| ev_tx | input | 2 | Per-channel transmit-empty event pulse |
| ext_in | input | 2 | Per-channel external/status condition level |
| data_rd | input | 2 | Per-channel data register read strobe |
| data_wr | input | 2 | Per-channel data register write strobe |
| cmd_we | input | 1 | Command write strobe |
| cmd_ch | input | 1 | Channel addressed by the command |
| cmd_code | input | 8 | Command code |
| vec_we | input | 1 | Vector register write strobe |
| vec_wdata | input | 8 | Vector register write data |
| mie | input | 1 | Master interrupt enable |
| src_en | input | 6 | Per-source enable |
| vis | input | 1 | Substitute source status into the vector |
| iei | input | 1 | Daisy-chain enable in |
| intack | input | 1 | Acknowledge cycle in progress |
| rd_n | input | 1 | Read strobe, active low |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Daisy-chain enable out |
| vec_raw | output | 8 | Vector register, unmodified |
| vec_mod | output | 8 | Vector register with optional status |
| ip_bits | output | 6 | Pending bits |

## Verification
Two kinds of operation can meet in one cycle: an event that sets a pending bit and a data access that clears the same bit, and a status-latch reopen together with a status input that already differs from the captured value. The bench drives the first pair in one cycle and expects the pending bit to stay set. For the second pair it expects the pending bit to read clear in the cycle of the reopen and set again in the next one. It also stacks two acknowledges to reach nested service, issues 0x38, and judges from `int_n` which of the two under-service bits was retired.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Source kinds inside one channel; the value is the offset within the channel's group
    typedef enum logic [1:0] {
        KIND_RX  = 2'd0,
        KIND_TX  = 2'd1,
        KIND_EXT = 2'd2
    } src_kind_e;

    localparam int SRC_PER_CH = 3;

    // Command codes
    localparam logic [7:0] CMD_RESET_EXT  = 8'h10;
    localparam logic [7:0] CMD_POP_SERVICE = 8'h38;

    // Flat index of a source
    function automatic int src_index(input int ch, input src_kind_e kind);
        return ch * SRC_PER_CH + int'(kind);
    endfunction

endpackage

// File: rtl/irq_ip_cell.sv
module irq_ip_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic ip_o
);
    // A set arriving with a clear is kept so that no event is lost
    always_ff @(posedge clk) begin
        if (rst) ip_o <= 1'b0;
        else     ip_o <= set_i | (ip_o & ~clr_i);
    end
endmodule

// File: rtl/irq_ext_latch.sv
module irq_ext_latch (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    input  logic reopen_i,
    output logic ip_o
);
    logic held_q;
    logic closed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= 1'b0;
            closed_q <= 1'b0;
            ip_o     <= 1'b0;
        end else if (reopen_i) begin
            closed_q <= 1'b0;
            ip_o     <= 1'b0;
        end else if (!closed_q && (cond_i != held_q)) begin
            held_q   <= cond_i;
            closed_q <= 1'b1;
            ip_o     <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o
);
    // Lowest index wins; idx_o is all ones when nothing is requested
    always_comb begin
        grant_o = '0;
        idx_o   = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ius_bank.sv
module irq_ius_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] grant_i,
    input  logic         pop_i,
    output logic [N-1:0] ius_o
);
    logic [N-1:0] lowest;
    logic [N-1:0] kept;

    always_comb begin
        lowest = ius_o & (~ius_o + N'(1));
        kept   = pop_i ? (ius_o & ~lowest) : ius_o;
    end

    always_ff @(posedge clk) begin
        if (rst) ius_o <= '0;
        else     ius_o <= kept | grant_i;
    end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl #(
    parameter int NCH      = 2,
    parameter int VEC_W    = 8,
    parameter int STAT_LSB = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       ev_rx,
    input  logic [NCH-1:0]       ev_tx,
    input  logic [NCH-1:0]       ext_in,
    input  logic [NCH-1:0]       data_rd,
    input  logic [NCH-1:0]       data_wr,
    input  logic                 cmd_we,
    input  logic [$clog2(NCH)-1:0] cmd_ch,
    input  logic [7:0]           cmd_code,
    input  logic                 vec_we,
    input  logic [VEC_W-1:0]     vec_wdata,
    input  logic                 mie,
    input  logic [NCH*3-1:0]     src_en,
    input  logic                 vis,
    input  logic                 iei,
    input  logic                 intack,
    input  logic                 rd_n,
    output logic                 int_n,
    output logic                 ieo,
    output logic [VEC_W-1:0]     vec_raw,
    output logic [VEC_W-1:0]     vec_mod
    ,output logic [NCH*3-1:0]    ip_bits
);
    import irq_pkg::*;

    localparam int NSRC  = NCH * SRC_PER_CH;
    localparam int IDX_W = $clog2(NSRC + 1);
    localparam int CH_W  = $clog2(NCH);

    logic [NSRC-1:0]  ip_q;
    logic [NSRC-1:0]  ius_q;
    logic [NSRC-1:0]  elig;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  ack_win;
    logic [NSRC-1:0]  ack_grant;
    logic [NSRC-1:0]  stat_win;
    logic [IDX_W-1:0] ack_idx;
    logic [IDX_W-1:0] stat_idx;
    logic [VEC_W-1:0] vec_q;
    logic             rd_q;
    logic             rd_fall;
    logic             ack_fire;
    logic             pop_cmd;
    logic             ext_cmd;

    // Per-channel pending sources
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int IRX  = c * SRC_PER_CH + int'(KIND_RX);
        localparam int ITX  = c * SRC_PER_CH + int'(KIND_TX);
        localparam int IEXT = c * SRC_PER_CH + int'(KIND_EXT);

        irq_ip_cell u_rx (
            .clk(clk), .rst(rst),
            .set_i(ev_rx[c]), .clr_i(data_rd[c]),
            .ip_o(ip_q[IRX])
        );
        irq_ip_cell u_tx (
            .clk(clk), .rst(rst),
            .set_i(ev_tx[c]), .clr_i(data_wr[c]),
            .ip_o(ip_q[ITX])
        );
        irq_ext_latch u_ext (
            .clk(clk), .rst(rst),
            .cond_i(ext_in[c]),
            .reopen_i(ext_cmd && (cmd_ch == CH_W'(c))),
            .ip_o(ip_q[IEXT])
        );
    end

    // Eligibility: enabled, pending, and nothing of equal or higher priority in service
    for (genvar i = 0; i < NSRC; i++) begin : g_elig
        assign elig[i] = mie & src_en[i] & ip_q[i] & ~(|ius_q[i:0]);
    end

    assign req   = elig & {NSRC{iei & ~intack}};
    assign int_n = ~(|req);
    assign ieo   = iei & ~(|ip_q) & ~(|ius_q);

    // Acknowledge: falling read strobe inside an acknowledge cycle
    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b1;
        else     rd_q <= rd_n;
    end
    assign rd_fall  = rd_q & ~rd_n;
    assign ack_fire = intack & iei & rd_fall;

    irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_ack_pick (
        .req_i(elig), .grant_o(ack_win), .idx_o(ack_idx)
    );
    assign ack_grant = ack_win & {NSRC{ack_fire}};

    assign pop_cmd = cmd_we && (cmd_code == CMD_POP_SERVICE);
    assign ext_cmd = cmd_we && (cmd_code == CMD_RESET_EXT);

    irq_ius_bank #(.N(NSRC)) u_ius (
        .clk(clk), .rst(rst),
        .grant_i(ack_grant), .pop_i(pop_cmd),
        .ius_o(ius_q)
    );

    // Vector register and status substitution
    always_ff @(posedge clk) begin
        if (rst)         vec_q <= '0;
        else if (vec_we) vec_q <= vec_wdata;
    end

    irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_stat_pick (
        .req_i(ip_q & src_en), .grant_o(stat_win), .idx_o(stat_idx)
    );

    always_comb begin
        vec_mod = vec_q;
        if (vis) vec_mod[STAT_LSB +: IDX_W] = stat_idx;
    end

    assign vec_raw = vec_q;
    assign ip_bits = ip_q;

    // Only the index form is used by the vector; the one-hot forms are kept local
    logic unused_ok;
    assign unused_ok = ^{stat_win, ack_idx};

endmodule

module sio_irq_chk #(
    parameter int NSRC = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            int_n,
    input logic            ieo,
    input logic            mie,
    input logic            iei,
    input logic            intack,
    input logic            rd_fall,
    input logic            cmd_we,
    input logic [7:0]      cmd_code,
    input logic [1:0]      data_wr,
    input logic [1:0]      ev_tx,
    input logic [NSRC-1:0] ip_q,
    input logic [NSRC-1:0] ius_q
);
    // R1: a request needs the master enable, the chain enable and no acknowledge
    p_int_gate_r1: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> (mie && iei && !intack));

    // R8: any pending or in-service bit blocks the chain
    p_ieo_block_r8: assert property (@(posedge clk) disable iff (rst)
        ((ip_q != '0) || (ius_q != '0)) |-> !ieo);

    // R5: new in-service bits only come from an acknowledge
    p_ius_from_ack_r5: assert property (@(posedge clk) disable iff (rst)
        ((ius_q & ~$past(ius_q)) != '0) |-> $past(intack && rd_fall));

    // R5: at most one bit per acknowledge
    p_ius_single_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(ius_q & ~$past(ius_q)) <= 1);

    // R7: the pop command retires exactly one bit
    p_pop_one_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_code == 8'h38 && ius_q != '0 && !(intack && rd_fall))
        |=> ($countones(ius_q) == $countones($past(ius_q)) - 1));

    // R3: a data write without a new event clears the transmit bit
    p_txclr_a_r3: assert property (@(posedge clk) disable iff (rst)
        (data_wr[0] && !ev_tx[0]) |=> !ip_q[1]);
    p_txclr_b_r3: assert property (@(posedge clk) disable iff (rst)
        (data_wr[1] && !ev_tx[1]) |=> !ip_q[4]);
endmodule

bind sio_irq_ctrl sio_irq_chk #(.NSRC(6)) u_chk (
    .clk(clk), .rst(rst), .int_n(int_n), .ieo(ieo), .mie(mie), .iei(iei),
    .intack(intack), .rd_fall(rd_fall), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .data_wr(data_wr), .ev_tx(ev_tx), .ip_q(ip_q), .ius_q(ius_q)
);

// File: tb/sim_sio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ev_rx = '0, ev_tx = '0, ext_in = '0, data_rd = '0, data_wr = '0;
    logic       cmd_we = 1'b0;
    logic [0:0] cmd_ch = '0;
    logic [7:0] cmd_code = '0;
    logic       vec_we = 1'b0;
    logic [7:0] vec_wdata = '0;
    logic       mie = 1'b1;
    logic [5:0] src_en = 6'h3F;
    logic       vis = 1'b0, iei = 1'b1, intack = 1'b0, rd_n = 1'b1;
    logic       int_n, ieo;
    logic [7:0] vec_raw, vec_mod;
    logic [5:0] ip_bits;

    always #2 clk = ~clk;

    sio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .ev_rx(ev_rx), .ev_tx(ev_tx), .ext_in(ext_in),
        .data_rd(data_rd), .data_wr(data_wr), .cmd_we(cmd_we), .cmd_ch(cmd_ch),
        .cmd_code(cmd_code), .vec_we(vec_we), .vec_wdata(vec_wdata), .mie(mie),
        .src_en(src_en), .vis(vis), .iei(iei), .intack(intack), .rd_n(rd_n),
        .int_n(int_n), .ieo(ieo), .vec_raw(vec_raw), .vec_mod(vec_mod),
        .ip_bits(ip_bits)
    );

    typedef struct {
        string      tag;
        logic       e_int;
        logic       e_ieo;
        logic [5:0] e_ip;
        logic [7:0] e_vm;
        logic [7:0] e_vr;
    } exp_t;

    exp_t expq[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic [7:0] exp_vr = 8'h00;

    // Monitor: results are settled one step after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t it;
                it = expq.pop_front();
                total++;
                if (int_n !== it.e_int || ieo !== it.e_ieo || ip_bits !== it.e_ip ||
                    vec_mod !== it.e_vm || vec_raw !== it.e_vr) begin
                    bad++;
                    $display("FAIL %s: int_n=%b ieo=%b ip=%h vm=%h vr=%h expected int_n=%b ieo=%b ip=%h vm=%h vr=%h",
                             it.tag, int_n, ieo, ip_bits, vec_mod, vec_raw,
                             it.e_int, it.e_ieo, it.e_ip, it.e_vm, it.e_vr);
                end
            end
        end
    end

    // Driver: inputs already applied at the falling edge; push the expectation, run one cycle
    task automatic cyc(input string tag, input logic e_int, input logic e_ieo,
                       input logic [5:0] e_ip, input logic [7:0] e_vm);
        exp_t it;
        it.tag = tag; it.e_int = e_int; it.e_ieo = e_ieo;
        it.e_ip = e_ip; it.e_vm = e_vm; it.e_vr = exp_vr;
        expq.push_back(it);
        @(posedge clk);
        @(negedge clk);
        ev_rx = '0; ev_tx = '0; data_rd = '0; data_wr = '0;
        cmd_we = 1'b0; cmd_code = '0; vec_we = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] code, input logic ch);
        cmd_we = 1'b1; cmd_code = code; cmd_ch = ch;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R11 reset state
        cyc("R11 reset", 1, 1, 6'h00, 8'h00);
        rst = 1'b0;
        vec_we = 1'b1; vec_wdata = 8'hA0; exp_vr = 8'hA0;
        cyc("R9 vector load", 1, 1, 6'h00, 8'hA0);

        // R1/R10/R2: B transmit is index 4
        ev_tx[1] = 1'b1;
        cyc("R10 B tx pending", 0, 0, 6'h10, 8'hA0);
        data_wr[1] = 1'b1;
        cyc("R3 data write clears tx", 1, 1, 6'h00, 8'hA0);

        // R1 gating terms
        mie = 1'b0; ev_rx[0] = 1'b1;
        cyc("R1 mie off", 1, 0, 6'h01, 8'hA0);
        mie = 1'b1;
        cyc("R1 mie on", 0, 0, 6'h01, 8'hA0);
        iei = 1'b0;
        cyc("R1 iei low", 1, 0, 6'h01, 8'hA0);
        iei = 1'b1; src_en[0] = 1'b0;
        cyc("R1 source disabled", 1, 0, 6'h01, 8'hA0);
        src_en[0] = 1'b1;

        // R3 set and clear collide: set wins
        ev_rx[0] = 1'b1; data_rd[0] = 1'b1;
        cyc("R3 set wins", 0, 0, 6'h01, 8'hA0);
        data_rd[0] = 1'b1;
        cyc("R3 data read clears rx", 1, 1, 6'h00, 8'hA0);

        // R4 status latch on channel A (index 2)
        ext_in[0] = 1'b1;
        cyc("R4 latch fires", 0, 0, 6'h04, 8'hA0);
        ext_in[0] = 1'b0;
        cyc("R4 closed latch holds", 0, 0, 6'h04, 8'hA0);
        cmd(8'h10, 1'b0);
        cyc("R4 reopen clears", 1, 1, 6'h00, 8'hA0);
        cyc("R4 refire after reopen", 0, 0, 6'h04, 8'hA0);
        cmd(8'h10, 1'b0);
        cyc("R4 second reopen clears", 1, 1, 6'h00, 8'hA0);
        cyc("R4 stays clear", 1, 1, 6'h00, 8'hA0);
        cmd(8'h10, 1'b1);
        cyc("R4 other channel reopen no effect", 1, 1, 6'h00, 8'hA0);

        // R5 acknowledge: A tx (1) beats B rx (3)
        ev_rx[1] = 1'b1; ev_tx[0] = 1'b1;
        cyc("R5 two pending", 0, 0, 6'h0A, 8'hA0);
        intack = 1'b1;
        cyc("R5 intack masks request", 1, 0, 6'h0A, 8'hA0);
        rd_n = 1'b0;
        cyc("R5 read strobe falls", 1, 0, 6'h0A, 8'hA0);
        intack = 1'b0; rd_n = 1'b1;
        cyc("R6 lower priority blocked", 1, 0, 6'h0A, 8'hA0);

        // R6 higher priority nests
        ev_rx[0] = 1'b1;
        cyc("R6 higher nests", 0, 0, 6'h0B, 8'hA0);
        intack = 1'b1;
        cyc("R5 second ack start", 1, 0, 6'h0B, 8'hA0);
        rd_n = 1'b0;
        cyc("R5 second ack", 1, 0, 6'h0B, 8'hA0);
        intack = 1'b0; rd_n = 1'b1;
        cyc("R6 all blocked while nested", 1, 0, 6'h0B, 8'hA0);

        // R7 pop retires the highest (index 0) first
        cmd(8'h38, 1'b0);
        cyc("R7 pop highest", 0, 0, 6'h0B, 8'hA0);
        data_rd[0] = 1'b1;
        cyc("R7 remaining service blocks", 1, 0, 6'h0A, 8'hA0);
        cmd(8'h38, 1'b0);
        cyc("R7 pop last", 0, 0, 6'h0A, 8'hA0);

        // R8 chain output
        data_wr[0] = 1'b1; data_rd[1] = 1'b1;
        cyc("R8 idle passes chain", 1, 1, 6'h00, 8'hA0);
        ev_tx[0] = 1'b1;
        cyc("R8 pending", 0, 0, 6'h02, 8'hA0);
        intack = 1'b1;
        cyc("R8 ack start", 1, 0, 6'h02, 8'hA0);
        rd_n = 1'b0;
        cyc("R8 ack", 1, 0, 6'h02, 8'hA0);
        intack = 1'b0; rd_n = 1'b1; data_wr[0] = 1'b1;
        cyc("R8 service alone blocks", 1, 0, 6'h00, 8'hA0);
        cmd(8'h38, 1'b0);
        cyc("R8 released", 1, 1, 6'h00, 8'hA0);

        // R9 status substitution
        vis = 1'b1; ev_tx[1] = 1'b1;
        cyc("R9 status B tx", 0, 0, 6'h10, 8'hA8);
        ev_rx[1] = 1'b1;
        cyc("R2 status picks B rx", 0, 0, 6'h18, 8'hA6);
        src_en[3] = 1'b0;
        cyc("R9 disabled source skipped", 0, 0, 6'h18, 8'hA8);
        src_en[3] = 1'b1; data_rd[1] = 1'b1; data_wr[1] = 1'b1;
        cyc("R9 none pending", 1, 1, 6'h00, 8'hAE);
        vis = 1'b0;
        cyc("R9 plain vector", 1, 1, 6'h00, 8'hA0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule